// File: doc/BRIEF.md
# Sticky Event Interrupt Aggregator

The block gathers up to 32 event lines into one interrupt request for a processor. Each line first passes through a two-stage synchroniser. It is then turned into an active-high form using that line's polarity setting. Depending on the line's setting, either a rising edge or a held active level latches the line's bit in a sticky status register. A software-written enable register masks status to form the pending word, and the single interrupt output is high while any pending bit is set.

The lower sixteen lines are reserved for on-chip event sources and always behave as rising-edge, active-high inputs. Lines from 16 upward are external. Their edge/level choice and their polarity come from two elaboration parameters, and the count of external lines is a parameter from 1 to 16. Software services an event by writing a one to that bit of the acknowledge word. If a level line is still active when its bit is acknowledged, the bit is set again in the same update, so the request persists until the source lets go.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset the status, pending and enable words read 0 and `irq_out` is low.
- R2: The pending word (read at byte offset 0x4) equals status AND enable, and `irq_out` is high exactly when any pending bit is 1.
- R3: The enable word is read/write at offset 0x8. A write takes effect at the clock edge that accepts it, and pending and `irq_out` follow from that edge on.
- R4: Lines 0 to 15 are rising-edge, active-high. A line held high after its bit is acknowledged does not set the bit again.
- R5: For an external line 16+k, bit k of `EXT_EDGE` selects edge (1) or level (0), and bit k of `EXT_HIGH` selects active-high (1) or active-low (0). An active-low line is asserted when its input is 0.
- R6: Writing offset 0xC clears every status bit written as 1 and leaves all other bits alone. Offset 0xC reads as 0.
- R7: A level line whose conditioned input is still active keeps its status bit at 1 through an acknowledge of that bit.
- R8: An edge event detected on the same clock edge as an acknowledge of its bit leaves the bit set.
- R9: Writes to offsets 0x0 (status) and 0x4 (pending) have no effect.
- R10: An input change becomes visible in status at the third rising clock edge after it is applied. The bit is still clear after the second edge.
- R11: A status bit stays set after its input goes inactive, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_raw | input | 16+EXT_LINES | Raw event lines, bit i is line i |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request, OR of pending bits |

## Verification
The bench builds the block with its defaults: sixteen external lines, `EXT_EDGE` = 0x00FF and `EXT_HIGH` = 0x0F0F. With these values the external lines come in four groups of four: edge/active-high at 16, edge/active-low at 20, level/active-high at 24 and level/active-low at 28. Every mix of sensitivity and polarity can therefore be reached with a single input bit. The full 32-bit width also exercises the top status bit and reads without zero padding.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned BASE_LINES = 16;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned BUS_AW     = 4;
  localparam logic [BUS_AW-1:0] OFS_STATUS = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_PEND   = 4'h4;
  localparam logic [BUS_AW-1:0] OFS_EN     = 4'h8;
  localparam logic [BUS_AW-1:0] OFS_ACK    = 4'hC;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic meta_q;
    logic out_q;
    // Reset to the line's inactive level so no false event follows reset.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= IDLE[i];
        out_q  <= IDLE[i];
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end
endmodule

// File: rtl/evt_detect.sv
module evt_detect #(
  parameter int unsigned N = 32,
  parameter logic [N-1:0] EDGE_MASK = '1,
  parameter logic [N-1:0] HIGH_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_in,
  output logic [N-1:0] hit
);
  logic [N-1:0] cond;
  logic [N-1:0] prev_q;

  assign cond = sync_in ^ ~HIGH_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cond;
  end

  for (genvar i = 0; i < N; i++) begin : g_kind
    if (EDGE_MASK[i]) begin : g_edge
      assign hit[i] = cond[i] & ~prev_q[i];
    end else begin : g_level
      assign hit[i] = cond[i];
    end
  end

  // R4: an edge line fires for one cycle only per transition
  a_r4_edge_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & EDGE_MASK) != '0) |=> ((hit & $past(hit) & EDGE_MASK) == '0));
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      hit,
  input  logic [BUS_AW-1:0] addr,
  input  logic              wen,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] rdata,
  output logic              irq
);
  logic [N-1:0] status_q, status_d;
  logic [N-1:0] enable_q, enable_d;
  logic [N-1:0] pending;
  logic [N-1:0] ack_clr;
  logic         ack_wr, en_wr, status_ce;

  assign ack_wr = wen && (addr == OFS_ACK);
  assign en_wr  = wen && (addr == OFS_EN);

  always_comb begin
    ack_clr   = ack_wr ? (wdata[N-1:0] & status_q) : '0;
    // New detections are ORed after the clear so they win over an acknowledge.
    status_d  = (status_q & ~ack_clr) | hit;
    status_ce = ack_wr || (hit != '0);
    enable_d  = wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (en_wr)     enable_q <= enable_d;
    end
  end

  assign pending = status_q & enable_q;
  assign irq     = |pending;

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_STATUS: rdata[N-1:0] = status_q;
      OFS_PEND:   rdata[N-1:0] = pending;
      OFS_EN:     rdata[N-1:0] = enable_q;
      default:    rdata = '0;
    endcase
  end

  // R6: an acknowledge with no competing detection clears the written bits
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && hit == '0) |=> ((status_q & $past(wdata[N-1:0])) == '0));
  // R11: status bits only fall through an acknowledge
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> (($past(status_q) & ~status_q) == '0));
  // R8/R10: every detection lands in status on the next edge
  a_r8_hit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));
  // R3: enable loads the written word
  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (enable_q == $past(wdata[N-1:0])));
  // R2: no request while every line is masked
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq);
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int unsigned EXT_LINES = 16,
  parameter logic [15:0] EXT_EDGE  = 16'h00FF,
  parameter logic [15:0] EXT_HIGH  = 16'h0F0F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BASE_LINES+EXT_LINES-1:0] src_raw,
  input  logic [BUS_AW-1:0]             bus_addr,
  input  logic                          bus_wen,
  input  logic [BUS_DW-1:0]             bus_wdata,
  output logic [BUS_DW-1:0]             bus_rdata,
  output logic                          irq_out
);
  localparam int unsigned N = BASE_LINES + EXT_LINES;
  localparam logic [N-1:0] EDGE_ALL = {EXT_EDGE[EXT_LINES-1:0], {BASE_LINES{1'b1}}};
  localparam logic [N-1:0] HIGH_ALL = {EXT_HIGH[EXT_LINES-1:0], {BASE_LINES{1'b1}}};
  localparam logic [N-1:0] IDLE_ALL = ~HIGH_ALL;

  logic [N-1:0] sync_q;
  logic [N-1:0] hit;

  evt_sync #(.N(N), .IDLE(IDLE_ALL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_raw), .q(sync_q)
  );

  evt_detect #(.N(N), .EDGE_MASK(EDGE_ALL), .HIGH_MASK(HIGH_ALL)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .hit(hit)
  );

  evt_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .addr(bus_addr), .wen(bus_wen), .wdata(bus_wdata),
    .rdata(bus_rdata), .irq(irq_out)
  );
endmodule

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;
  localparam logic [31:0] IDLE = 32'hF0F0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_raw;
  logic [3:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  evt_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .bus_addr(bus_addr),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wen   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wen   = 1'b0;
  endtask

  task automatic quiesce();
    src_raw = IDLE;
    tick(4);
    wr(4'hC, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v); chk("R1 status", v, 0);
    rd(4'h4, v); chk("R1 pending", v, 0);
    rd(4'h8, v); chk("R1 enable", v, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);
  endtask

  task automatic t_base_edge();
    logic [31:0] v;
    src_raw[3] = 1'b1;
    tick(2);
    rd(4'h0, v); chk("R10 not yet", v, 0);
    tick(1);
    rd(4'h0, v); chk("R10 landed", v, 32'h8);
    chk("R2 masked irq", {31'b0, irq_out}, 0);
    wr(4'h8, 32'h8);
    rd(4'h4, v); chk("R2 pending", v, 32'h8);
    chk("R3 irq after enable", {31'b0, irq_out}, 1);
    rd(4'h8, v); chk("R3 enable read", v, 32'h8);
    wr(4'hC, 32'h8);
    tick(3);
    rd(4'h0, v); chk("R4 no refire while held", v, 0);
    chk("R6 irq dropped", {31'b0, irq_out}, 0);
    quiesce();
  endtask

  task automatic t_sticky_pulse();
    logic [31:0] v;
    src_raw[16] = 1'b1;
    tick(1);
    src_raw[16] = 1'b0;
    tick(5);
    rd(4'h0, v); chk("R11 pulse held", v, 32'h0001_0000);
    quiesce();
  endtask

  task automatic t_active_low_edge();
    logic [31:0] v;
    src_raw[20] = 1'b0;
    tick(3);
    rd(4'h0, v); chk("R5 low edge fires", v, 32'h0010_0000);
    wr(4'hC, 32'h0010_0000);
    src_raw[20] = 1'b1;
    tick(4);
    rd(4'h0, v); chk("R5 release quiet", v, 0);
    quiesce();
  endtask

  task automatic t_level();
    logic [31:0] v;
    src_raw[24] = 1'b1;
    tick(3);
    rd(4'h0, v); chk("R5 level high", v, 32'h0100_0000);
    wr(4'hC, 32'h0100_0000);
    rd(4'h0, v); chk("R7 reasserted", v, 32'h0100_0000);
    src_raw[24] = 1'b0;
    tick(4);
    wr(4'hC, 32'h0100_0000);
    rd(4'h0, v); chk("R7 clears when idle", v, 0);
    src_raw[28] = 1'b0;
    tick(3);
    rd(4'h0, v); chk("R5 level low", v, 32'h1000_0000);
    quiesce();
  endtask

  task automatic t_writes_ignored();
    logic [31:0] v;
    src_raw[1] = 1'b1;
    tick(3);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R9 status write ignored", v, 32'h2);
    wr(4'hC, 32'h0000_0400);
    rd(4'h0, v); chk("R6 other bits kept", v, 32'h2);
    rd(4'hC, v); chk("R6 ack reads zero", v, 0);
    quiesce();
  endtask

  task automatic t_collision();
    logic [31:0] v;
    src_raw[5] = 1'b1;
    tick(3);
    src_raw[5] = 1'b0;
    tick(4);
    rd(4'h0, v); chk("R8 first event", v, 32'h20);
    src_raw[5] = 1'b1;
    tick(2);
    wr(4'hC, 32'h20);
    rd(4'h0, v); chk("R8 new edge wins", v, 32'h20);
    quiesce();
  endtask

  initial begin
    rst_n = 1'b0;
    src_raw = IDLE;
    bus_addr = 4'h0;
    bus_wen = 1'b0;
    bus_wdata = 32'h0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_base_edge();
    t_sticky_pulse();
    t_active_low_edge();
    t_level();
    t_writes_ignored();
    t_collision();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule